// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

This block is a match-based timer. A single up-counter is compared against a bank of match registers. A programmable event control word ties each event to one match register. Every output owns a set mask and a clear mask, each with one bit per event. When several events reach one output in the same cycle, a two-bit resolution field for that output decides whether it holds, goes high, goes low or toggles. A limit mask names the events that return the counter to zero, and this gives every channel the same period.

Software configures the block through a simple word-wide write and read port. A PWM channel is normally built from two events. The period event sets the output and also wraps the counter. The duty event clears the output. The resolution field for that output is programmed to "set", so a duty equal to the period yields a constant high. Inverting the polarity swaps the two events and uses "clear". A halt bit freezes counting, and a prescaler slows the count rate. Each match register has a reload register that is copied into it at every wrap.

Top module: `ectmr_top`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0x4 (halted, prescale 0), the outputs are low, and every limit bit, event control word, set mask and clear mask reads zero.
- R2: While control bit 2 (halt) is set, the counter and the outputs do not change. The prescale field at control bits 12:5 holds P, and a running counter advances once every P+1 clocks.
- R3: Event e fires for exactly one clock, on an advance cycle, when bit 12 of its control word is set and the match register chosen by control bits 3:0 equals the counter. An event whose control word is zero, or whose bit 12 is clear, never fires.
- R4: On an advance cycle where an event selected in the limit register (bit e for event e) fires, the counter becomes 0 instead of incrementing. A limit match of N-1 therefore gives a period of N counts.
- R5: An output goes high on an advance cycle when an event in its set mask fires. It goes low when an event in its clear mask fires. It holds its value when neither kind of event fires.
- R6: When set and clear events reach output o in the same cycle, the field at resolution register bits 2o+1:2o decides the result: 0 holds, 1 sets, 2 clears, 3 toggles.
- R7: A write to a match register takes effect at once. When a limit event fires and configuration bit 7 is clear, every match register loads from its reload register. While configuration bit 7 is set, no such load happens.
- R8: A period event that sets and limits, a duty event that clears, and resolution "set" give a high time of duty+1 counts out of the period, and a constant high when duty equals the period match. The swapped inverted form with resolution "clear" gives the complement.
- R9: Byte addresses are as follows. Configuration 0x000, control 0x004, limit 0x008, resolution 0x00C, and counter 0x010 (read only). Match i is at 0x100+4i, reload i at 0x200+4i and event control i at 0x300+4i. The set mask of output o is at 0x400+8o and its clear mask at 0x404+8o. Every writable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 12 | Byte address for read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| pwm_out | output | 16 | Registered output vector |

## Verification
An event that is evaluated with a wrong counter, prescale phase or match value shows up on pwm_out within one period. It appears as a changed high count, a missing edge or a wrong wrap point. The bench therefore compares the counter and all outputs against a behavioural model on every clock. A reload that is missed, or that happens when it should not, changes the period that the counter readback shows within the next wrap. A wrong conflict policy only shows in cycles where set and clear coincide, so duty equal to period, toggle and hold cases are each driven on purpose.

// File: rtl/ectmr_pkg.sv
package ectmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [3:0] RGN_CORE    = 4'h0;
  localparam logic [3:0] RGN_MATCH   = 4'h1;
  localparam logic [3:0] RGN_RELOAD  = 4'h2;
  localparam logic [3:0] RGN_EVCTL   = 4'h3;
  localparam logic [3:0] RGN_OUTMASK = 4'h4;

  localparam logic [7:0] OFF_CFG   = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_LIMIT = 8'h08;
  localparam logic [7:0] OFF_RES   = 8'h0C;
  localparam logic [7:0] OFF_COUNT = 8'h10;

  localparam int CFG_NORELOAD_BIT = 7;
  localparam int CTRL_HALT_BIT    = 2;
  localparam int CTRL_PRE_LSB     = 5;
  localparam int EV_ON_BIT        = 12;

  typedef enum logic [1:0] {
    RES_HOLD = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2,
    RES_TGL  = 2'd3
  } res_act_e;
endpackage

// File: rtl/ectmr_regs.sv
module ectmr_regs import ectmr_pkg::*; #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  localparam int SEL_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  input  logic                              wrap_pulse,
  input  logic [CNT_W-1:0]                  count,
  output logic                              no_reload,
  output logic                              halt,
  output logic [PRE_W-1:0]                  pre,
  output logic [NUM_EV-1:0]                 limit_mask,
  output logic [NUM_OUT-1:0][1:0]           res_sel,
  output logic [NUM_EV-1:0][CNT_W-1:0]      match_val,
  output logic [NUM_EV-1:0][SEL_W-1:0]      ev_sel,
  output logic [NUM_EV-1:0]                 ev_on,
  output logic [NUM_OUT-1:0][NUM_EV-1:0]    set_mask,
  output logic [NUM_OUT-1:0][NUM_EV-1:0]    clr_mask
);
  logic [3:0] rgn;
  logic       aligned;
  logic       wr_core, wr_cfg, wr_ctrl, wr_limit, wr_res;
  logic       load_all;

  assign rgn      = addr[11:8];
  assign aligned  = (addr[1:0] == 2'b00);
  assign wr_core  = we && aligned && (rgn == RGN_CORE);
  assign wr_cfg   = wr_core && (addr[7:0] == OFF_CFG);
  assign wr_ctrl  = wr_core && (addr[7:0] == OFF_CTRL);
  assign wr_limit = wr_core && (addr[7:0] == OFF_LIMIT);
  assign wr_res   = wr_core && (addr[7:0] == OFF_RES);
  assign load_all = wrap_pulse && !no_reload;

  // core control registers
  logic                 no_reload_d, halt_d;
  logic [PRE_W-1:0]     pre_d;
  logic [NUM_EV-1:0]    limit_d;
  logic [2*NUM_OUT-1:0] res_q, res_d;

  always_comb begin
    no_reload_d = wdata[CFG_NORELOAD_BIT];
    halt_d      = wdata[CTRL_HALT_BIT];
    pre_d       = wdata[CTRL_PRE_LSB +: PRE_W];
    limit_d     = wdata[NUM_EV-1:0];
    res_d       = wdata[2*NUM_OUT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      no_reload  <= 1'b0;
      halt       <= 1'b1;
      pre        <= '0;
      limit_mask <= '0;
      res_q      <= '0;
    end else begin
      if (wr_cfg)   no_reload  <= no_reload_d;
      if (wr_ctrl)  halt       <= halt_d;
      if (wr_ctrl)  pre        <= pre_d;
      if (wr_limit) limit_mask <= limit_d;
      if (wr_res)   res_q      <= res_d;
    end
  end

  assign res_sel = res_q;

  // per-event match, reload and event control
  logic [NUM_EV-1:0][CNT_W-1:0] reload_q;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    logic             wr_m, wr_r, wr_e, match_en;
    logic [CNT_W-1:0] match_d;

    assign wr_m = we && aligned && (rgn == RGN_MATCH)  && (addr[7:2] == 6'(i));
    assign wr_r = we && aligned && (rgn == RGN_RELOAD) && (addr[7:2] == 6'(i));
    assign wr_e = we && aligned && (rgn == RGN_EVCTL)  && (addr[7:2] == 6'(i));

    always_comb begin
      match_en = wr_m || load_all;
      match_d  = wr_m ? wdata[CNT_W-1:0] : reload_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_val[i] <= '0;
        reload_q[i]  <= '0;
        ev_sel[i]    <= '0;
        ev_on[i]     <= 1'b0;
      end else begin
        if (match_en) match_val[i] <= match_d;
        if (wr_r)     reload_q[i]  <= wdata[CNT_W-1:0];
        if (wr_e)     ev_sel[i]    <= wdata[SEL_W-1:0];
        if (wr_e)     ev_on[i]     <= wdata[EV_ON_BIT];
      end
    end
  end

  // per-output set and clear masks
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic wr_s, wr_c;
    assign wr_s = we && (rgn == RGN_OUTMASK) && (addr[2:0] == 3'b000) && (addr[7:3] == 5'(o));
    assign wr_c = we && (rgn == RGN_OUTMASK) && (addr[2:0] == 3'b100) && (addr[7:3] == 5'(o));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_mask[o] <= '0;
        clr_mask[o] <= '0;
      end else begin
        if (wr_s) set_mask[o] <= wdata[NUM_EV-1:0];
        if (wr_c) clr_mask[o] <= wdata[NUM_EV-1:0];
      end
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    case (rgn)
      RGN_CORE: begin
        case (addr[7:0])
          OFF_CFG:   rdata[CFG_NORELOAD_BIT] = no_reload;
          OFF_CTRL: begin
            rdata[CTRL_HALT_BIT]              = halt;
            rdata[CTRL_PRE_LSB +: PRE_W]      = pre;
          end
          OFF_LIMIT: rdata[NUM_EV-1:0]    = limit_mask;
          OFF_RES:   rdata[2*NUM_OUT-1:0] = res_q;
          OFF_COUNT: rdata[CNT_W-1:0]     = count;
          default:   rdata = '0;
        endcase
      end
      RGN_MATCH: begin
        for (int i = 0; i < NUM_EV; i++)
          if (addr[7:2] == 6'(i)) rdata[CNT_W-1:0] = match_val[i];
      end
      RGN_RELOAD: begin
        for (int i = 0; i < NUM_EV; i++)
          if (addr[7:2] == 6'(i)) rdata[CNT_W-1:0] = reload_q[i];
      end
      RGN_EVCTL: begin
        for (int i = 0; i < NUM_EV; i++)
          if (addr[7:2] == 6'(i)) begin
            rdata[SEL_W-1:0]  = ev_sel[i];
            rdata[EV_ON_BIT]  = ev_on[i];
          end
      end
      RGN_OUTMASK: begin
        for (int o = 0; o < NUM_OUT; o++)
          if (addr[7:3] == 5'(o))
            rdata[NUM_EV-1:0] = addr[2] ? clr_mask[o] : set_mask[o];
      end
      default: rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata;
endmodule

// File: rtl/ectmr_count.sv
module ectmr_count #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [PRE_W-1:0] pre,
  input  logic             limit_hit,
  output logic             tick,
  output logic [CNT_W-1:0] count
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = !halt && (pre_q >= pre);
    pre_d = (halt || tick) ? '0 : pre_q + 1'b1;
    cnt_d = limit_hit ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else begin
      pre_q <= pre_d;
      if (tick) count <= cnt_d;
    end
  end
endmodule

// File: rtl/ectmr_events.sv
module ectmr_events #(
  parameter int NUM_EV = 16,
  parameter int CNT_W  = 32,
  localparam int SEL_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic                         tick,
  input  logic [CNT_W-1:0]             count,
  input  logic [NUM_EV-1:0][CNT_W-1:0] match_val,
  input  logic [NUM_EV-1:0][SEL_W-1:0] ev_sel,
  input  logic [NUM_EV-1:0]            ev_on,
  input  logic [NUM_EV-1:0]            limit_mask,
  output logic [NUM_EV-1:0]            fire,
  output logic                         limit_hit
);
  for (genvar e = 0; e < NUM_EV; e++) begin : g_fire
    logic [CNT_W-1:0] sel_match;
    always_comb begin
      sel_match = '0;
      for (int k = 0; k < NUM_EV; k++)
        if (ev_sel[e] == SEL_W'(k)) sel_match = match_val[k];
      fire[e] = tick && ev_on[e] && (sel_match == count);
    end
  end

  assign limit_hit = |(fire & limit_mask);
endmodule

// File: rtl/ectmr_outs.sv
module ectmr_outs import ectmr_pkg::*; #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_EV-1:0]              fire,
  input  logic [NUM_OUT-1:0][NUM_EV-1:0] set_mask,
  input  logic [NUM_OUT-1:0][NUM_EV-1:0] clr_mask,
  input  logic [NUM_OUT-1:0][1:0]        res_sel,
  output logic [NUM_OUT-1:0]             pwm_out
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_pin
    logic hit_s, hit_c, out_d, out_en;

    always_comb begin
      hit_s  = |(fire & set_mask[o]);
      hit_c  = |(fire & clr_mask[o]);
      out_en = hit_s || hit_c;
      out_d  = pwm_out[o];
      if (hit_s && hit_c) begin
        case (res_act_e'(res_sel[o]))
          RES_SET:  out_d = 1'b1;
          RES_CLR:  out_d = 1'b0;
          RES_TGL:  out_d = !pwm_out[o];
          default:  out_d = pwm_out[o];
        endcase
      end else if (hit_s) begin
        out_d = 1'b1;
      end else if (hit_c) begin
        out_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pwm_out[o] <= 1'b0;
      else if (out_en) pwm_out[o] <= out_d;
    end
  end
endmodule

// File: rtl/ectmr_top.sv
module ectmr_top import ectmr_pkg::*; #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  output logic [NUM_OUT-1:0] pwm_out
);
  localparam int SEL_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                           no_reload, halt, tick, limit_hit;
  logic [PRE_W-1:0]               pre;
  logic [CNT_W-1:0]               count;
  logic [NUM_EV-1:0]              limit_mask, ev_on, fire;
  logic [NUM_OUT-1:0][1:0]        res_sel;
  logic [NUM_EV-1:0][CNT_W-1:0]   match_val;
  logic [NUM_EV-1:0][SEL_W-1:0]   ev_sel;
  logic [NUM_OUT-1:0][NUM_EV-1:0] set_mask, clr_mask;

  ectmr_regs #(.NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .wrap_pulse(limit_hit), .count(count), .no_reload(no_reload),
    .halt(halt), .pre(pre), .limit_mask(limit_mask), .res_sel(res_sel),
    .match_val(match_val), .ev_sel(ev_sel), .ev_on(ev_on),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  ectmr_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) count_i (
    .clk(clk), .rst_n(rst_core_n), .halt(halt), .pre(pre),
    .limit_hit(limit_hit), .tick(tick), .count(count)
  );

  ectmr_events #(.NUM_EV(NUM_EV), .CNT_W(CNT_W)) events_i (
    .tick(tick), .count(count), .match_val(match_val), .ev_sel(ev_sel),
    .ev_on(ev_on), .limit_mask(limit_mask), .fire(fire), .limit_hit(limit_hit)
  );

  ectmr_outs #(.NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT)) outs_i (
    .clk(clk), .rst_n(rst_core_n), .fire(fire), .set_mask(set_mask),
    .clr_mask(clr_mask), .res_sel(res_sel), .pwm_out(pwm_out)
  );

  logic unused_top;
  assign unused_top = no_reload;
endmodule

// File: rtl/ectmr_chk.sv
module ectmr_chk #(
  parameter int NUM_EV  = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               halt,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_EV-1:0]  fire,
  input logic [NUM_EV-1:0]  limit_mask,
  input logic [NUM_OUT-1:0] pwm_out
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(count)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count)); // R2

  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> (fire == '0)); // R3

  AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && |(fire & limit_mask)) |=> (count == '0)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(|(fire & limit_mask))) |=> (count == CNT_W'($past(count) + 1'b1))); // R4

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == '0) |=> $stable(pwm_out)); // R5
endmodule

bind ectmr_top ectmr_chk #(.NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_core_n), .tick(tick), .halt(halt), .count(count),
  .fire(fire), .limit_mask(limit_mask), .pwm_out(pwm_out)
);

// File: tb/ectmr_top_tb_top.sv
module ectmr_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [15:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  ectmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  bit [31:0] m_match [16];
  bit [31:0] m_reload [16];
  bit [3:0]  m_evsel [16];
  bit        m_evon [16];
  bit [15:0] m_set [16];
  bit [15:0] m_clr [16];
  bit [31:0] m_res;
  bit [15:0] m_limit;
  bit        m_nrl, m_halt;
  int        m_pre, m_pcnt;
  bit [31:0] m_cnt;
  bit [15:0] m_out;

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, lh, s, c;
    bit [15:0] ev;
    int idx;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_match[i] = 0; m_reload[i] = 0; m_evsel[i] = 0; m_evon[i] = 0;
        m_set[i] = 0; m_clr[i] = 0;
      end
      m_res = 0; m_limit = 0; m_nrl = 0; m_halt = 1; m_pre = 0; m_pcnt = 0;
      m_cnt = 0; m_out = 0;
    end else begin
      tk = !m_halt && (m_pcnt >= m_pre);
      ev = 0;
      if (tk)
        for (int e = 0; e < 16; e++)
          if (m_evon[e] && m_match[m_evsel[e]] == m_cnt) ev[e] = 1;
      lh = |(ev & m_limit);
      for (int o = 0; o < 16; o++) begin
        s = |(ev & m_set[o]);
        c = |(ev & m_clr[o]);
        if (s && c) begin
          case (m_res[2*o +: 2])
            2'd1: m_out[o] = 1;
            2'd2: m_out[o] = 0;
            2'd3: m_out[o] = !m_out[o];
            default: ;
          endcase
        end else if (s) m_out[o] = 1;
        else if (c) m_out[o] = 0;
      end
      if (tk && lh && !m_nrl)
        for (int i = 0; i < 16; i++) m_match[i] = m_reload[i];
      if (tk) m_cnt = lh ? 0 : m_cnt + 1;
      m_pcnt = (m_halt || tk) ? 0 : m_pcnt + 1;
      if (cfg_we) begin
        idx = int'(cfg_addr[7:2]);
        case (cfg_addr[11:8])
          4'h0: case (cfg_addr[7:0])
                  8'h00: m_nrl = cfg_wdata[7];
                  8'h04: begin m_halt = cfg_wdata[2]; m_pre = int'(cfg_wdata[12:5]); end
                  8'h08: m_limit = cfg_wdata[15:0];
                  8'h0C: m_res = cfg_wdata;
                  default: ;
                endcase
          4'h1: if (idx < 16) m_match[idx] = cfg_wdata;
          4'h2: if (idx < 16) m_reload[idx] = cfg_wdata;
          4'h3: if (idx < 16) begin m_evsel[idx] = cfg_wdata[3:0]; m_evon[idx] = cfg_wdata[12]; end
          4'h4: if (int'(cfg_addr[7:3]) < 16) begin
                  if (cfg_addr[2]) m_clr[cfg_addr[6:3]] = cfg_wdata[15:0];
                  else             m_set[cfg_addr[6:3]] = cfg_wdata[15:0];
                end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison of outputs and counter (R3 R4 R5 R6 R7)
  always @(negedge clk) begin
    if (cmp_on) begin
      check(pwm_out == m_out, "R5 per-cycle outputs", pwm_out, m_out);
      check(dut_i.count_i.count == m_cnt, "R4 per-cycle counter", dut_i.count_i.count, m_cnt);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic high_count(input int b, input int n, output int highs);
    highs = 0;
    repeat (n) begin
      @(negedge clk);
      highs += int'(pwm_out[b]);
    end
  endtask

  task automatic count_changes(input int n, output int changes);
    logic [31:0] prev;
    changes = 0;
    @(negedge clk);
    cfg_addr = 12'h010;
    #1;
    prev = cfg_rdata;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (cfg_rdata != prev) changes++;
      prev = cfg_rdata;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int h;
    logic [31:0] snap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    rd_check(12'h004, 32'h4, "R1 control after reset");
    rd_check(12'h010, 32'h0, "R1 counter after reset");
    rd_check(12'h008, 32'h0, "R1 limit after reset");
    rd_check(12'h300, 32'h0, "R1 event control after reset");
    rd_check(12'h404, 32'h0, "R1 clear mask after reset");
    check(pwm_out == 16'h0, "R1 outputs after reset", pwm_out, 0);

    // R8 normal PWM on out0, inverted on out1, period 10, duty match 3
    wr(12'h100, 9);  wr(12'h200, 9);  wr(12'h300, 32'h1000);
    wr(12'h104, 3);  wr(12'h204, 3);  wr(12'h304, 32'h1001);
    wr(12'h008, 1);
    wr(12'h400, 1);  wr(12'h404, 2);
    wr(12'h408, 2);  wr(12'h40C, 1);
    wr(12'h00C, 32'h9);
    wr(12'h004, 0);
    repeat (25) @(negedge clk);
    high_count(0, 20, h);
    check(h == 8, "R8 normal polarity high count", h, 8);
    high_count(1, 20, h);
    check(h == 12, "R8 inverted polarity high count", h, 12);
    count_changes(20, h);
    check(h == 20, "R4 counter advances each clock", h, 20);

    // R8 R6 duty equal to period
    wr(12'h104, 9);  wr(12'h204, 9);
    repeat (25) @(negedge clk);
    high_count(0, 20, h);
    check(h == 20, "R8 R6 duty==period constant high", h, 20);
    high_count(1, 20, h);
    check(h == 0, "R8 R6 inverted duty==period constant low", h, 0);

    // R6 toggle on out2
    wr(12'h410, 1);  wr(12'h414, 1);  wr(12'h00C, 32'h39);
    repeat (15) @(negedge clk);
    high_count(2, 20, h);
    check(h == 10, "R6 toggle resolution", h, 10);

    // R6 hold on out3: first set by event 2, then coincident set and clear with policy 0
    wr(12'h108, 5);  wr(12'h308, 32'h1002);  wr(12'h418, 4);
    repeat (15) @(negedge clk);
    check(pwm_out[3] == 1'b1, "R5 set by event mask", pwm_out[3], 1);
    wr(12'h418, 1);  wr(12'h41C, 1);
    repeat (5) @(negedge clk);
    high_count(3, 20, h);
    check(h == 20, "R6 hold resolution", h, 20);

    // R3 event control zero and enable bit clear never fire
    wr(12'h308, 0);  wr(12'h420, 4);
    wr(12'h30C, 32'h0002);  wr(12'h428, 8);
    repeat (5) @(negedge clk);
    high_count(4, 20, h);
    check(h == 0, "R3 zero control word never fires", h, 0);
    high_count(5, 20, h);
    check(h == 0, "R3 enable bit clear never fires", h, 0);

    // R2 prescaler 2
    wr(12'h004, 32'h40);
    repeat (5) @(negedge clk);
    count_changes(30, h);
    check(h == 10, "R2 prescale advances every P+1 clocks", h, 10);

    // R2 halt
    wr(12'h004, 32'h4);
    repeat (2) @(negedge clk);
    cfg_addr = 12'h010;
    #1 snap = cfg_rdata;
    repeat (10) @(negedge clk);
    #1;
    check(cfg_rdata == snap, "R2 halt freezes counter", cfg_rdata, snap);

    // R7 reload behaviour
    wr(12'h200, 5);
    rd_check(12'h100, 32'd9, "R7 reload write does not touch match");
    wr(12'h004, 0);
    repeat (25) @(negedge clk);
    rd_check(12'h100, 32'd5, "R7 match loaded at wrap");
    wr(12'h000, 32'h80);
    wr(12'h200, 9);
    repeat (25) @(negedge clk);
    rd_check(12'h100, 32'd5, "R7 no load while reload disabled");
    wr(12'h100, 7);
    rd_check(12'h100, 32'd7, "R7 match write immediate");

    // R9 readback of writable registers
    rd_check(12'h00C, 32'h39, "R9 resolution readback");
    rd_check(12'h000, 32'h80, "R9 configuration readback");
    rd_check(12'h30C, 32'h2, "R9 event control readback");
    rd_check(12'h40C, 32'h1, "R9 clear mask readback");
    repeat (20) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule